// File: doc/BRIEF.md
# Transmit System-Bus Frame Timebase

This block keeps the bit and frame position of a T1 or E1 transmit system bus. It runs on the bus clock and counts bit positions inside a frame (193 for T1, 256 for E1) and frames inside a multiframe (24 for T1, 16 for E1). It exports the running position so that neighbouring logic can address time slots. A single sync line carries either a frame pulse or a multiframe pulse. That pulse sits at a programmable time-slot and bit offset from the frame boundary and can change on either edge of the bus clock.

When the block is master, it drives the sync line. When it is slaved to the bus, or when the transmit framer is disabled, it releases the line. It then watches an incoming sync and moves its counters onto it whenever that sync arrives at an unexpected position. A double-rate option covers a bus clock running at twice the data rate. The option is honoured only while the slip buffer is in use, not bypassed. All configuration arrives as static inputs, and a new configuration is applied under reset.

Top module: `tx_bus_timebase`

## Requirements
- R1: A synchronous active-low reset puts `bit_cnt` and `frm_cnt` at 0 and holds `sync_out` and `resync` low.
- R2: `bit_cnt` counts 0 to 192 when `e1_mode`=0 and 0 to 255 when `e1_mode`=1, then returns to 0. On that return `frm_cnt` advances.
- R3: `frm_cnt` counts 0 to 23 in T1 and 0 to 15 in E1, then returns to 0.
- R4: The sync target is `slot_ofs`*8+`bit_ofs`, reduced by the frame length when it reaches or exceeds it. Offset 0 is the frame boundary. In master mode, `sync_out` is high for exactly the clock cycle that follows each cycle in which `bit_cnt` equals the target.
- R5: With `mf_select`=1, the sync pulse appears only when `frm_cnt` is 0 at the target position. With `mf_select`=0 it appears in every frame.
- R6: With `fall_edge`=0, `sync_out` changes on the rising clock edge. With `fall_edge`=1 it changes on the following falling edge, half a cycle later.
- R7: `sync_oe` is 1 only when `slave_mode`=0 and `framer_off`=0. While `sync_oe` is 0, `sync_out` stays 0.
- R8: With `dbl_rate`=1 and `slip_bypass`=0, the position advances on every second clock, starting with the second clock after reset or realignment. With `slip_bypass`=1 the position advances every clock, whatever `dbl_rate` is.
- R9: When `sync_oe` is 0 and `sync_in` rises at a position other than the target, the counters reload to the position that follows the target. The frame count is set to 0 (then wrapped as in R2) when `mf_select`=1 and kept otherwise. The rate phase restarts, and `resync` goes high for exactly one cycle.
- R10: A rising `sync_in` at the target position (and at frame 0 when `mf_select`=1) leaves the counting unchanged and does not raise `resync`.
- R11: While `sync_oe` is 1, `sync_in` has no effect on the counters or on `resync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e1_mode | input | 1 | 0: 193-bit T1 frame, 1: 256-bit E1 frame |
| mf_select | input | 1 | 0: sync line carries the frame pulse, 1: the multiframe pulse |
| slave_mode | input | 1 | 1: timebase follows the incoming sync |
| framer_off | input | 1 | 1: transmit framer disabled, so the sync line is an input |
| slot_ofs | input | 5 | Time-slot offset of the sync pulse |
| bit_ofs | input | 3 | Bit offset of the sync pulse |
| fall_edge | input | 1 | 1: sync output changes on the falling edge |
| dbl_rate | input | 1 | 1: bus clock at twice the data rate |
| slip_bypass | input | 1 | 1: slip buffer bypassed, which disables double rate |
| sync_in | input | 1 | Incoming sync when not master |
| sync_out | output | 1 | Outgoing frame or multiframe sync |
| sync_oe | output | 1 | Output enable of the sync line |
| bit_cnt | output | 8 | Bit position in the frame |
| frm_cnt | output | 5 | Frame position in the multiframe |
| resync | output | 1 | One-cycle flag after a realignment |

## Verification
The first directed patterns drive master mode with offsets at the frame boundary, at the E1 last bit, and at a T1 offset past the frame end. Together they separate correct offset arithmetic from a missing modulo reduction or a mis-wrapped frame length. Full multiframe runs, with and without double rate, show whether the multiframe pulse is gated to frame zero and whether the half-rate phase is honoured or wrongly applied under slip bypass. Sampling the output both before and after the falling edge shows which edge the output follows. In slave mode, syncs placed at mismatched and at matched positions show whether the block reloads and flags only when it should. A randomized mix of configurations with noise on `sync_in` in master mode then shows that the input is ignored where it must be.

// File: rtl/tbt_pkg.sv
`timescale 1ns/1ps
package tbt_pkg;
  localparam int T1_BITS = 193;
  localparam int E1_BITS = 256;
  localparam int T1_MF   = 24;
  localparam int E1_MF   = 16;
  localparam int POS_W   = 8;
  localparam int FRM_W   = 5;
  localparam int SLOT_W  = 5;
  localparam int BOFS_W  = 3;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [FRM_W-1:0] frm_t;
  typedef logic [POS_W:0]   len_t;

  function automatic len_t frame_len(input logic e1);
    return e1 ? len_t'(E1_BITS) : len_t'(T1_BITS);
  endfunction

  function automatic pos_t bit_last(input logic e1);
    len_t l;
    l = frame_len(e1) - len_t'(1);
    return l[POS_W-1:0];
  endfunction

  function automatic frm_t mf_last(input logic e1);
    return e1 ? frm_t'(E1_MF - 1) : frm_t'(T1_MF - 1);
  endfunction

  // slot * 8 + bit, folded back into the frame when past its end
  function automatic pos_t sync_target(input logic e1,
                                       input logic [SLOT_W-1:0] slot,
                                       input logic [BOFS_W-1:0] bofs);
    len_t raw;
    raw = len_t'({slot, bofs});
    if (raw >= frame_len(e1)) raw = raw - frame_len(e1);
    return raw[POS_W-1:0];
  endfunction
endpackage

// File: rtl/tbt_rate_phase.sv
`timescale 1ns/1ps
module tbt_rate_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl_eff,
  input  logic restart,
  output logic adv
);
  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !dbl_eff) phase <= 1'b0;
    else                               phase <= ~phase;
  end

  assign adv = dbl_eff ? phase : 1'b1;

  // in double rate an advance is never followed by another one
  assert_half_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_eff && adv && !restart) |=> (!adv || !dbl_eff));
endmodule

// File: rtl/tbt_pos_counter.sv
`timescale 1ns/1ps
module tbt_pos_counter import tbt_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic e1,
  input  logic adv,
  input  logic load,
  input  pos_t load_tgt,
  input  logic load_mf,
  output pos_t bit_pos,
  output frm_t frm_idx
);
  logic bit_wrap, frm_wrap, tgt_wrap;
  frm_t frm_inc;

  assign bit_wrap = (bit_pos == bit_last(e1));
  assign frm_wrap = (frm_idx == mf_last(e1));
  assign tgt_wrap = (load_tgt == bit_last(e1));
  assign frm_inc  = frm_wrap ? '0 : frm_idx + frm_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_pos <= '0;
      frm_idx <= '0;
    end else if (load) begin
      bit_pos <= tgt_wrap ? '0 : load_tgt + pos_t'(1);
      if (load_mf) frm_idx <= tgt_wrap ? frm_t'(1) : '0;
      else if (tgt_wrap) frm_idx <= frm_inc;
    end else if (adv) begin
      bit_pos <= bit_wrap ? '0 : bit_pos + pos_t'(1);
      if (bit_wrap) frm_idx <= frm_inc;
    end
  end

  assert_bit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= bit_last(e1));
  assert_frm_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_idx <= mf_last(e1));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> ($stable(bit_pos) && $stable(frm_idx)));
  assert_reset_zero_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (bit_pos == '0 && frm_idx == '0));
endmodule

// File: rtl/tbt_sync_drive.sv
`timescale 1ns/1ps
module tbt_sync_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic drive_en,
  input  logic fall_edge,
  output logic sync_out
);
  logic sync_q, sync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= hit && drive_en;
  end

  // half-cycle retimed copy for falling-edge output
  always_ff @(negedge clk) begin
    if (!rst_n) sync_n <= 1'b0;
    else        sync_n <= sync_q;
  end

  assign sync_out = fall_edge ? sync_n : sync_q;

  assert_fall_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n == sync_q);
  assert_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> !sync_q);
endmodule

// File: rtl/tx_bus_timebase.sv
`timescale 1ns/1ps
module tx_bus_timebase import tbt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e1_mode,
  input  logic              mf_select,
  input  logic              slave_mode,
  input  logic              framer_off,
  input  logic [SLOT_W-1:0] slot_ofs,
  input  logic [BOFS_W-1:0] bit_ofs,
  input  logic              fall_edge,
  input  logic              dbl_rate,
  input  logic              slip_bypass,
  input  logic              sync_in,
  output logic              sync_out,
  output logic              sync_oe,
  output logic [POS_W-1:0]  bit_cnt,
  output logic [FRM_W-1:0]  frm_cnt,
  output logic              resync
);
  logic master, dbl_eff, adv, at_target, sync_in_q, in_rise, realign;
  pos_t tgt, bit_pos;
  frm_t frm_idx;

  assign master    = !slave_mode && !framer_off;
  assign dbl_eff   = dbl_rate && !slip_bypass;
  assign tgt       = sync_target(e1_mode, slot_ofs, bit_ofs);
  assign at_target = (bit_pos == tgt) && (!mf_select || frm_idx == '0);
  assign in_rise   = !master && sync_in && !sync_in_q;
  assign realign   = in_rise && !at_target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_in_q <= 1'b0;
      resync    <= 1'b0;
    end else begin
      sync_in_q <= sync_in;
      resync    <= realign;
    end
  end

  tbt_rate_phase u_phase (
    .clk(clk), .rst_n(rst_n), .dbl_eff(dbl_eff), .restart(realign), .adv(adv)
  );

  tbt_pos_counter u_pos (
    .clk(clk), .rst_n(rst_n), .e1(e1_mode), .adv(adv), .load(realign),
    .load_tgt(tgt), .load_mf(mf_select), .bit_pos(bit_pos), .frm_idx(frm_idx)
  );

  tbt_sync_drive u_drive (
    .clk(clk), .rst_n(rst_n), .hit(at_target), .drive_en(master),
    .fall_edge(fall_edge), .sync_out(sync_out)
  );

  assign sync_oe = master;
  assign bit_cnt = bit_pos;
  assign frm_cnt = frm_idx;

  assert_quiet_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_oe |-> !sync_out);
  assert_flag_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> resync);
  assert_flag_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);
  assert_match_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rise && at_target) |=> !resync);
  assert_master_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    master |=> !resync);
endmodule

// File: tb/tx_bus_timebase_test.sv
`timescale 1ns/1ps
module tx_bus_timebase_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic e1_mode = 0, mf_select = 0, slave_mode = 0, framer_off = 0;
  logic [4:0] slot_ofs = 0;
  logic [2:0] bit_ofs = 0;
  logic fall_edge = 0, dbl_rate = 0, slip_bypass = 0, sync_in = 0;
  logic sync_out, sync_oe, resync;
  logic [7:0] bit_cnt;
  logic [4:0] frm_cnt;

  tx_bus_timebase uut (
    .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .mf_select(mf_select),
    .slave_mode(slave_mode), .framer_off(framer_off), .slot_ofs(slot_ofs),
    .bit_ofs(bit_ofs), .fall_edge(fall_edge), .dbl_rate(dbl_rate),
    .slip_bypass(slip_bypass), .sync_in(sync_in), .sync_out(sync_out),
    .sync_oe(sync_oe), .bit_cnt(bit_cnt), .frm_cnt(frm_cnt), .resync(resync)
  );

  int checks = 0, errors = 0, rs_seen = 0, n_adv = 0;
  bit ph = 0, sin_prev = 0, exp_q = 0, exp_q_prev = 0, exp_rs = 0;

  function automatic int b_flen(); return e1_mode ? 256 : 193; endfunction
  function automatic int b_mflen(); return e1_mode ? 16 : 24; endfunction
  function automatic int b_target();
    return (int'(slot_ofs) * 8 + int'(bit_ofs)) % b_flen();
  endfunction
  function automatic bit b_pre_hit();
    int fl = b_flen();
    return ((n_adv % fl) == b_target()) &&
           (!mf_select || ((n_adv / fl) % b_mflen()) == 0);
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // R1: reset state
  task automatic do_reset();
    rst_n = 0;
    sync_in = 0;
    repeat (3) @(posedge clk);
    #6;
    check("R1", bit_cnt, 0);
    check("R1", frm_cnt, 0);
    check("R1", sync_out, 0);
    check("R1", resync, 0);
    rst_n = 1;
    n_adv = 0; ph = 0; sin_prev = 0; exp_q = 0; exp_rs = 0;
  endtask

  task automatic step(bit sin, string tp, string ts);
    int fl, ml, tg, bp, fp;
    bit master, hit, rise, dbl_eff, adv;
    fl = b_flen(); ml = b_mflen(); tg = b_target();
    sync_in = sin;
    @(posedge clk);
    bp = n_adv % fl;
    fp = (n_adv / fl) % ml;
    master = !slave_mode && !framer_off;
    hit = b_pre_hit();
    rise = !master && sin && !sin_prev;
    sin_prev = sin;
    exp_q_prev = exp_q;
    exp_q = master && hit;
    if (rise && !hit) begin
      n_adv = mf_select ? tg + 1 : fp * fl + tg + 1;
      ph = 0;
      exp_rs = 1;
    end else begin
      dbl_eff = dbl_rate && !slip_bypass;
      adv = dbl_eff ? ph : 1'b1;
      ph = dbl_eff ? !ph : 1'b0;
      n_adv += int'(adv);
      exp_rs = 0;
    end
    n_adv = n_adv % (fl * ml);
    #2;
    check("R6", sync_out, fall_edge ? exp_q_prev : exp_q);
    #4;
    check(tp, bit_cnt, n_adv % fl);
    check("R3", frm_cnt, (n_adv / fl) % ml);
    check(ts, sync_out, exp_q);
    check("R9", resync, exp_rs);
    check("R7", sync_oe, master);
    rs_seen += int'(resync);
  endtask

  task automatic run(int n, string tp, string ts);
    for (int i = 0; i < n; i++) step(1'b0, tp, ts);
  endtask

  task automatic cfg(bit e1, bit mf, bit sl, bit off, int so, int bo,
                     bit fe, bit dr, bit byp);
    e1_mode = e1; mf_select = mf; slave_mode = sl; framer_off = off;
    slot_ofs = 5'(so); bit_ofs = 3'(bo); fall_edge = fe;
    dbl_rate = dr; slip_bypass = byp;
    do_reset();
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int seed, rs0;
    seed = $urandom(32'h1c0de);
    // R2 R4: T1 boundary pulse
    cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
    run(600, "R2", "R4");
    // R4 R6: E1 last bit, falling edge
    cfg(1, 0, 0, 0, 31, 7, 1, 0, 0);
    run(600, "R2", "R4");
    // R4: T1 offset past frame end folds back to 62
    cfg(0, 0, 0, 0, 31, 7, 0, 0, 0);
    run(400, "R2", "R4");
    // R5 R3: T1 multiframe pulse
    cfg(0, 1, 0, 0, 2, 3, 1, 0, 0);
    run(24 * 193 + 300, "R3", "R5");
    // R8 R5: E1 multiframe at double rate
    cfg(1, 1, 0, 0, 4, 1, 0, 1, 0);
    run(2 * 16 * 256 + 200, "R8", "R5");
    // R8: bypass forces single rate
    cfg(0, 0, 0, 0, 1, 1, 0, 1, 1);
    run(500, "R8", "R4");
    check("R8", bit_cnt, 500 % 193);
    // R9 R10: slave realignment
    cfg(0, 0, 1, 0, 5, 2, 0, 0, 0);
    run(300, "R2", "R7");
    step(1'b1, "R9", "R7");
    run(50, "R9", "R7");
    rs0 = rs_seen;
    for (int i = 0; i < 400; i++) step(b_pre_hit(), "R10", "R7");
    check("R10", rs_seen - rs0, 0);
    // R9: mismatched multiframe sync in double rate
    cfg(1, 1, 1, 0, 9, 6, 0, 1, 0);
    run(700, "R2", "R7");
    step(1'b1, "R9", "R7");
    run(900, "R9", "R7");
    // R7: framer disabled behaves as input
    cfg(0, 0, 0, 1, 3, 0, 1, 0, 0);
    run(100, "R2", "R7");
    step(1'b1, "R9", "R7");
    run(300, "R9", "R7");
    // R11: master with noise on sync_in
    cfg(1, 0, 0, 0, 7, 4, 0, 0, 0);
    rs0 = rs_seen;
    for (int i = 0; i < 1500; i++) step(1'($urandom % 7 == 0), "R11", "R4");
    check("R11", rs_seen - rs0, 0);
    // random configurations
    for (int k = 0; k < 10; k++) begin
      cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
          int'($urandom % 32), int'($urandom % 8), 1'($urandom),
          1'($urandom), 1'($urandom));
      for (int i = 0; i < 2500; i++)
        step(1'($urandom % 150 == 0), "R2", "R4");
    end
    summary();
  end
endmodule